// File: doc/BRIEF.md
# Register-Mapped Modular Adder

This block is a small arithmetic peripheral that sits behind a word-indexed register port. Software loads two operands, writes a start request into a control field, and then reads back the sum together with a ready flag. The sum wraps modulo 2^DATA_W, so no carry leaves the block.

The port has four word slots, selected by a 2-bit index. Slot 0 holds operand X, slot 1 holds operand Y, and slot 2 holds the result Z, which cannot be written. Slot 3 is a combined word. Its low half is a control field that software may write. Its high half is a status field that only the core sets. Bit 0 of the control field is the start request, and bit 0 of the status field (word bit CTRL_W, bit 16 at the default width) is the ready flag.

A three-state sequencer runs the core. The states are `ST_IDLE` (no result pending, ready clear), `ST_CALC` (start accepted, the sum is taken at the next edge) and `ST_DONE` (Z valid, ready set). The transitions are:
- start: any state to `ST_CALC`, on a slot-3 write with bit 0 set.
- finish: `ST_CALC` to `ST_DONE`, when no operand is written in that cycle.
- abort: `ST_CALC` to `ST_IDLE`, on an operand write.
- invalidate: `ST_DONE` to `ST_IDLE`, on an operand write.

Top module: `madd_periph`

## Requirements
- R1: After reset all four slots read as zero: X, Y, Z and the combined word.
- R2: A write to slot 0 loads X and a write to slot 1 loads Y. Each keeps all DATA_W bits and reads back unchanged.
- R3: Z is the sum (X + Y) mod 2^DATA_W of the operand values held when the sum is taken. For example, 0xAA55A5A5 + 0x11221212 = 0xBB77B7B7 and 0xFFFFFFFF + 0x00000001 = 0x00000000.
- R4: A write to slot 3 loads the control field (bits CTRL_W-1:0) from the write data. Write data in the status field (the upper bits) is ignored.
- R5: A slot-3 write with bit 0 set, in the edge that captures it, makes Z and the ready flag update at the following edge. After the start write, slot 3 reads 0x00010001.
- R6: Any write to slot 0 or slot 1 clears the ready flag until the next start. Z keeps its previous value. An operand write in the cycle right after a start cancels that sum.
- R7: Writes to slot 2 have no effect on Z or on any other slot.
- R8: A read changes no state. rd_data shows the selected slot while rd_en is high and is zero while rd_en is low.
- R9: A slot-3 write with bit 0 clear starts nothing. Z and the ready flag keep their values.
- R10: In the cycle between the start write and the sum, slot 3 still shows the previous ready value (clear if it was clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx | input | 2 | Word slot select |
| wr_en | input | 1 | Write strobe for the selected slot |
| rd_en | input | 1 | Read strobe for the selected slot |
| wr_data | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Read data, zero when rd_en is low |

## Verification
The bench builds the block at the default DATA_W of 32, which gives a CTRL_W of 16. At this width the ready flag sits at word bit 16, so the literal word 0x00010001 and the carry chain across all 32 bits, including the wrap of 0xFFFFFFFF + 1 to zero, are checked directly. A behavioural model in the bench tracks a pending-sum flag, and the bench compares against it on every clock. The compared cases include an operand write in the cycle just after a start and a read in the cycle between a start and its sum.

// File: rtl/madd_pkg.sv
package madd_pkg;
    localparam int IDX_W = 2;

    localparam logic [IDX_W-1:0] SLOT_X   = 2'd0;
    localparam logic [IDX_W-1:0] SLOT_Y   = 2'd1;
    localparam logic [IDX_W-1:0] SLOT_Z   = 2'd2;
    localparam logic [IDX_W-1:0] SLOT_CSR = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/madd_regs.sv
module madd_regs
    import madd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CTRL_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] opx_q,
    output logic [DATA_W-1:0] opy_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              op_wr,
    output logic              start_req
);
    localparam int N_OPS = 2;

    logic [DATA_W-1:0] ops_q [N_OPS];
    logic              csr_wr;

    assign csr_wr    = wr_en && (reg_idx == SLOT_CSR);
    assign op_wr     = wr_en && ((reg_idx == SLOT_X) || (reg_idx == SLOT_Y));
    assign start_req = csr_wr && wr_data[0];

    // One register per operand; the slot index matches the loop position.
    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ops_q[g] <= '0;
            end else if (wr_en && (reg_idx == IDX_W'(g))) begin
                ops_q[g] <= wr_data;
            end
        end
    end

    assign opx_q = ops_q[0];
    assign opy_q = ops_q[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (csr_wr) begin
            ctrl_q <= wr_data[CTRL_W-1:0];
        end
    end

    assert_ctrl_low_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_idx == SLOT_CSR) |=> (ctrl_q == $past(wr_data[CTRL_W-1:0])));

    assert_operand_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_idx == SLOT_X) |=> (opx_q == $past(wr_data)));

    assert_slot2_no_touch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_idx == SLOT_Z) |=> ($stable(opx_q) && $stable(opy_q) && $stable(ctrl_q)));
endmodule

// File: rtl/madd_seq.sv
module madd_seq
    import madd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              op_wr,
    input  logic [DATA_W-1:0] opx,
    input  logic [DATA_W-1:0] opy,
    output logic [DATA_W-1:0] sum_q,
    output logic              ready_q
);
    seq_state_e state_q, state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: start, finish, abort, invalidate.
    always_comb begin
        state_d = state_q;
        if (start_req) begin
            state_d = ST_CALC;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_CALC: state_d = op_wr ? ST_IDLE : ST_DONE;
                ST_DONE: state_d = op_wr ? ST_IDLE : ST_DONE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs: the sum and the ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q   <= '0;
            ready_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_CALC: begin
                    if (op_wr) begin
                        ready_q <= 1'b0;
                    end else begin
                        sum_q   <= opx + opy;
                        ready_q <= 1'b1;
                    end
                end
                ST_IDLE, ST_DONE: begin
                    if (op_wr) begin
                        ready_q <= 1'b0;
                    end
                end
                default: ready_q <= 1'b0;
            endcase
        end
    end

    assert_sum_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CALC && !op_wr) |=> (sum_q == $past(opx + opy)));

    assert_ready_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req) |=> ##1 (ready_q || $past(op_wr)));

    assert_op_clears_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_wr |=> !ready_q);

    assert_sum_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_CALC) |=> $stable(sum_q));
endmodule

// File: rtl/madd_rdmux.sv
module madd_rdmux
    import madd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CTRL_W = DATA_W / 2
) (
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] opx,
    input  logic [DATA_W-1:0] opy,
    input  logic [DATA_W-1:0] sum,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              ready,
    output logic [DATA_W-1:0] rd_data
);
    localparam int STAT_W = DATA_W - CTRL_W;

    logic [STAT_W-1:0] status;

    assign status = {{(STAT_W-1){1'b0}}, ready};

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (reg_idx)
                SLOT_X:   rd_data = opx;
                SLOT_Y:   rd_data = opy;
                SLOT_Z:   rd_data = sum;
                SLOT_CSR: rd_data = {status, ctrl};
                default:  rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/madd_periph.sv
module madd_periph
    import madd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_idx,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int CTRL_W = DATA_W / 2;

    logic [DATA_W-1:0] opx, opy, sum;
    logic [CTRL_W-1:0] ctrl;
    logic              op_wr, start_req, ready;

    madd_regs #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .reg_idx   (reg_idx),
        .wr_data   (wr_data),
        .opx_q     (opx),
        .opy_q     (opy),
        .ctrl_q    (ctrl),
        .op_wr     (op_wr),
        .start_req (start_req)
    );

    madd_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .op_wr     (op_wr),
        .opx       (opx),
        .opy       (opy),
        .sum_q     (sum),
        .ready_q   (ready)
    );

    madd_rdmux #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_rdmux (
        .rd_en   (rd_en),
        .reg_idx (reg_idx),
        .opx     (opx),
        .opy     (opy),
        .sum     (sum),
        .ctrl    (ctrl),
        .ready   (ready),
        .rd_data (rd_data)
    );

    assert_read_no_side_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> ($stable(opx) && $stable(opy) && $stable(ctrl)));

    assert_reset_zero_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (opx == '0 && opy == '0 && sum == '0 && ctrl == '0 && !ready));
endmodule

// File: tb/madd_periph_test.sv
module madd_periph_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    reg_idx = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // Reference model state.
    logic [DW-1:0] m_x = '0, m_y = '0, m_z = '0;
    logic [15:0]   m_ctrl = '0;
    bit            m_ready = 0;
    bit            m_pend = 0;

    madd_periph #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en),
        .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] model_read(input logic [1:0] i);
        case (i)
            2'd0: return m_x;
            2'd1: return m_y;
            2'd2: return m_z;
            default: return {15'd0, m_ready, m_ctrl};
        endcase
    endfunction

    // Behavioural model, updated at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_x = '0; m_y = '0; m_z = '0; m_ctrl = '0; m_ready = 0; m_pend = 0;
        end else begin
            bit opw;
            opw = wr_en && (reg_idx == 2'd0 || reg_idx == 2'd1);
            if (m_pend && !opw) begin
                m_z = m_x + m_y;
                m_ready = 1;
            end
            if (opw) m_ready = 0;
            m_pend = 0;
            if (wr_en) begin
                case (reg_idx)
                    2'd0: m_x = wr_data;
                    2'd1: m_y = wr_data;
                    2'd3: begin
                        m_ctrl = wr_data[15:0];
                        m_pend = wr_data[0];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Every-clock comparison against the model (R8 covers rd_en low -> zero).
    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n) begin
            logic [DW-1:0] exp;
            exp = rd_en ? model_read(reg_idx) : '0;
            n_cmp++;
            if (rd_data !== exp) begin
                n_bad++;
                $display("FAIL model R8 idx=%0d rd_en=%0b actual=%h expected=%h",
                         reg_idx, rd_en, rd_data, exp);
            end
        end
    end

    task automatic wr(input logic [1:0] i, input logic [DW-1:0] d);
        @(negedge clk);
        reg_idx = i; wr_en = 1'b1; rd_en = 1'b0; wr_data = d;
    endtask

    task automatic rd(input logic [1:0] i, input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        reg_idx = i; wr_en = 1'b0; rd_en = 1'b1; wr_data = '0;
        #(CLK_PERIOD/4 + 1);
        n_cmp++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s idx=%0d actual=%h expected=%h", tag, i, rd_data, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int i = 0; i < 4; i++) rd(i[1:0], '0, "R1");
        // R2: operand load
        wr(2'd0, 32'hAA55A5A5);
        wr(2'd1, 32'h11221212);
        rd(2'd0, 32'hAA55A5A5, "R2");
        rd(2'd1, 32'h11221212, "R2");
        rd(2'd3, 32'h00000000, "R1");
        // R5/R10: start, then read in the cycle before the sum
        wr(2'd3, 32'h00000001);
        rd(2'd3, 32'h00000001, "R10");
        rd(2'd3, 32'h00010001, "R5");
        rd(2'd2, 32'hBB77B7B7, "R3");
        // R4/R9: status half ignored, bit 0 clear starts nothing
        wr(2'd3, 32'hFFFF0002);
        idle();
        rd(2'd3, 32'h00010002, "R4");
        rd(2'd2, 32'hBB77B7B7, "R9");
        // R7: slot 2 write ignored
        wr(2'd2, 32'h12345678);
        rd(2'd2, 32'hBB77B7B7, "R7");
        rd(2'd0, 32'hAA55A5A5, "R7");
        // R6: operand write clears ready, Z kept
        wr(2'd0, 32'hFFFFFFFF);
        rd(2'd3, 32'h00000002, "R6");
        rd(2'd2, 32'hBB77B7B7, "R6");
        // R3: wrap-around
        wr(2'd1, 32'h00000001);
        wr(2'd3, 32'h00000001);
        idle();
        rd(2'd2, 32'h00000000, "R3");
        rd(2'd3, 32'h00010001, "R5");
        // R6: operand write right after start cancels the sum
        wr(2'd0, 32'h00000005);
        wr(2'd1, 32'h00000007);
        wr(2'd3, 32'h00000001);
        wr(2'd0, 32'h00000009);
        idle();
        rd(2'd3, 32'h00000001, "R6");
        rd(2'd2, 32'h00000000, "R6");
        // restart uses current operands: 9 + 7
        wr(2'd3, 32'h00000001);
        idle();
        rd(2'd2, 32'h00000010, "R3");
        // R8: repeated reads change nothing
        rd(2'd3, 32'h00010001, "R8");
        rd(2'd3, 32'h00010001, "R8");
        rd(2'd2, 32'h00000010, "R8");
        idle();
        idle();
        summary();
    end
endmodule